// File: doc/BRIEF.md
# Serial segment-display command and data receiver

This block takes 8-bit words from a host over a synchronous serial link made of a shift clock, a data line, an active-low chip select and a command/data select line. All of these inputs are brought into the system clock domain with two-stage synchronisers, and their edges are detected there. Each finished word is routed by the level of the select line on its eighth clock edge. A word taken as display data writes two 4-bit nibbles into a 32-entry display memory. A word taken as a command either changes the display mode or moves the write address.

A 5-bit address counter steps forward after every write and wraps at the top of the memory. The display mode goes out as a registered 2-bit code to the waveform generator. A second, independent read port gives the segment scanner access to the memory. An active-low panel reset input puts the block back into its power-up display state.

Top module: `seg_lcd_link`

## Requirements
- R1: Serial clock edges count only while `cs_n` is low. A high-to-low transition of `cs_n` discards any partly received word.
- R2: Bits are sampled on rising edges of `sck`. Each word is 8 bits long and arrives most significant bit first.
- R3: The level of `cmd_sel` matters only at the 8th rising edge of a word: 1 makes the word a command, 0 makes it display data.
- R4: A display data word writes its bits 7:4 to the current address and its bits 3:0 to the current address + 1. The address then ends 2 higher.
- R5: The command `000AAAAA` loads the address counter with AAAAA.
- R6: Commands with bits 7:5 = 001, 010 and 011 set `disp_mode` to 01 (all segments lit), 00 (all dark) and 10 (normal, from memory) respectively. None of them changes the memory.
- R7: The command `100xDDDD` writes DDDD to the current address and then advances the address by 1. Bit 4 has no effect.
- R8: The command with bits 7:5 = 110, and also a low level on `panel_rst_n`, set `disp_mode` to 00 and clear the address to 0.
- R9: The address wraps from 31 to 0. A data word written at address 31 puts its low nibble at address 0 and leaves the address at 1.
- R10: Commands with bits 7:5 = 101 or 111 change neither the mode, the address nor the memory.
- R11: `scan_data` shows the memory entry at `scan_addr` one clock after `scan_addr` is presented.
- R12: While `rst` is high, `disp_mode` is 00 and the address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial shift clock (asynchronous) |
| sdi | input | 1 | Serial data, MSB first |
| cmd_sel | input | 1 | 1 = command, 0 = display data; sampled on the 8th edge |
| cs_n | input | 1 | Active-low chip select |
| panel_rst_n | input | 1 | Active-low display reset |
| scan_addr | input | 5 | Scanner read address |
| scan_data | output | 4 | Memory nibble at the scanner address, registered |
| disp_mode | output | 2 | 00 dark, 01 all lit, 10 normal |

## Verification
The assertions assume that each serial input stays stable for several system clocks around every `sck` rise. They also assume that `cs_n` never falls in the same cycle as a synchronised `sck` rise, and that two words are at least a few system clocks apart, so a second nibble write never meets a new word. The bench holds every `sck` level for six to eight system clocks. It changes `sdi`, `cmd_sel` and `cs_n` only while `sck` is low, and it leaves idle time after each word before the model is compared again.

// File: rtl/seg_lcd_pkg.sv
package seg_lcd_pkg;
  localparam int WORD_W = 8;
  localparam int NIB_W  = WORD_W / 2;
  localparam int ADDR_W = 5;

  typedef enum logic [1:0] {
    MODE_DARK = 2'b00,
    MODE_LIT  = 2'b01,
    MODE_RAM  = 2'b10
  } disp_mode_t;

  localparam logic [2:0] OP_ADDR  = 3'b000;
  localparam logic [2:0] OP_LIT   = 3'b001;
  localparam logic [2:0] OP_DARK  = 3'b010;
  localparam logic [2:0] OP_RAM   = 3'b011;
  localparam logic [2:0] OP_NIB   = 3'b100;
  localparam logic [2:0] OP_CLEAR = 3'b110;
endpackage

// File: rtl/seg_lcd_sync.sv
module seg_lcd_sync #(
  parameter int          W    = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta  <= INIT;
      d_out <= INIT;
    end else begin
      meta  <= d_in;
      d_out <= meta;
    end
  end
endmodule

// File: rtl/seg_lcd_shift.sv
module seg_lcd_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_s,
  input  logic              sd_s,
  input  logic              cd_s,
  input  logic              cs_n_s,
  output logic              word_vld,
  output logic [WORD_W-1:0] word,
  output logic              word_cmd
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              sck_q, cs_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shreg;
  logic              sck_rise, cs_fall;

  assign sck_rise = sck_s & ~sck_q;
  assign cs_fall  = ~cs_n_s & cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q    <= 1'b0;
      cs_q     <= 1'b1;
      bit_cnt  <= '0;
      shreg    <= '0;
      word     <= '0;
      word_vld <= 1'b0;
      word_cmd <= 1'b0;
    end else begin
      sck_q    <= sck_s;
      cs_q     <= cs_n_s;
      word_vld <= 1'b0;
      if (cs_fall) begin
        bit_cnt <= '0;
      end else if (sck_rise && !cs_n_s) begin
        shreg <= {shreg[WORD_W-2:0], sd_s};
        if (bit_cnt == LAST) begin
          bit_cnt  <= '0;
          word_vld <= 1'b1;
          word     <= {shreg[WORD_W-2:0], sd_s};
          word_cmd <= cd_s;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // R1: a falling chip select restarts the bit count
  a_r1_cnt_clear: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> (bit_cnt == '0));
  // R1: a word completes only while selected
  a_r1_word_in_cs: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> !$past(cs_n_s));
  // R3: word class follows the select level at the final edge
  a_r3_class_last_edge: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> (word_cmd == $past(cd_s)));
endmodule

// File: rtl/seg_lcd_ctrl.sv
module seg_lcd_ctrl
  import seg_lcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              prst_n_s,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word,
  input  logic              word_cmd,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [NIB_W-1:0]  wr_nib,
  output disp_mode_t        disp_mode
);
  logic [ADDR_W-1:0] addr;
  logic              lo_pend;
  logic [NIB_W-1:0]  lo_nib;
  logic [2:0]        op;

  assign op = word[WORD_W-1 -: 3];

  always_ff @(posedge clk) begin
    if (rst || !prst_n_s) begin
      addr      <= '0;
      lo_pend   <= 1'b0;
      lo_nib    <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_nib    <= '0;
      disp_mode <= MODE_DARK;
    end else begin
      wr_en   <= 1'b0;
      lo_pend <= 1'b0;
      if (lo_pend) begin
        wr_en   <= 1'b1;
        wr_addr <= addr;
        wr_nib  <= lo_nib;
        addr    <= addr + 1'b1;
      end else if (word_vld && !word_cmd) begin
        wr_en   <= 1'b1;
        wr_addr <= addr;
        wr_nib  <= word[WORD_W-1 -: NIB_W];
        lo_nib  <= word[NIB_W-1:0];
        lo_pend <= 1'b1;
        addr    <= addr + 1'b1;
      end else if (word_vld) begin
        case (op)
          OP_ADDR:  addr      <= word[ADDR_W-1:0];
          OP_LIT:   disp_mode <= MODE_LIT;
          OP_DARK:  disp_mode <= MODE_DARK;
          OP_RAM:   disp_mode <= MODE_RAM;
          OP_NIB: begin
            wr_en   <= 1'b1;
            wr_addr <= addr;
            wr_nib  <= word[NIB_W-1:0];
            addr    <= addr + 1'b1;
          end
          OP_CLEAR: begin
            disp_mode <= MODE_DARK;
            addr      <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  // R4: a data word is followed by two writes to consecutive addresses
  a_r4_pair_start: assert property (@(posedge clk) disable iff (rst || !prst_n_s)
    (word_vld && !word_cmd) |=> (wr_en && lo_pend));
  a_r4_pair_next: assert property (@(posedge clk) disable iff (rst || !prst_n_s)
    lo_pend |=> (wr_en && wr_addr == $past(wr_addr) + 1'b1));
  // R7: the single-nibble command writes the low four bits
  a_r7_nib_write: assert property (@(posedge clk) disable iff (rst || !prst_n_s)
    (word_vld && word_cmd && op == OP_NIB) |=> (wr_en && wr_nib == $past(word[NIB_W-1:0])));
  // R6: the mode code is never the unused value
  a_r6_mode_legal: assert property (@(posedge clk) disable iff (rst)
    disp_mode != 2'b11);
  // R8: a low panel reset leaves the display dark
  a_r8_panel_dark: assert property (@(posedge clk) disable iff (rst)
    !prst_n_s |=> (disp_mode == MODE_DARK && !wr_en));
endmodule

// File: rtl/seg_lcd_ram.sv
module seg_lcd_ram #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/seg_lcd_link.sv
module seg_lcd_link
  import seg_lcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              sdi,
  input  logic              cmd_sel,
  input  logic              cs_n,
  input  logic              panel_rst_n,
  input  logic [ADDR_W-1:0] scan_addr,
  output logic [NIB_W-1:0]  scan_data,
  output logic [1:0]        disp_mode
);
  localparam int NSYNC = 5;

  logic [NSYNC-1:0]  raw, synced;
  logic              word_vld, word_cmd, wr_en;
  logic [WORD_W-1:0] word;
  logic [ADDR_W-1:0] wr_addr;
  logic [NIB_W-1:0]  wr_nib;
  disp_mode_t        mode;

  assign raw = {panel_rst_n, cs_n, cmd_sel, sdi, sck};

  seg_lcd_sync #(.W(NSYNC), .INIT(5'b11000)) u_sync (
    .clk(clk), .rst(rst), .d_in(raw), .d_out(synced));

  seg_lcd_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst),
    .sck_s(synced[0]), .sd_s(synced[1]), .cd_s(synced[2]), .cs_n_s(synced[3]),
    .word_vld(word_vld), .word(word), .word_cmd(word_cmd));

  seg_lcd_ctrl u_ctrl (
    .clk(clk), .rst(rst), .prst_n_s(synced[4]),
    .word_vld(word_vld), .word(word), .word_cmd(word_cmd),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_nib(wr_nib), .disp_mode(mode));

  seg_lcd_ram #(.ADDR_W(ADDR_W), .DATA_W(NIB_W)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_nib),
    .raddr(scan_addr), .rdata(scan_data));

  assign disp_mode = mode;

  // R12: reset holds the display dark
  a_r12_reset_dark: assert property (@(posedge clk)
    $past(rst) |-> (disp_mode == 2'b00));
endmodule

// File: tb/seg_lcd_link_bench.sv
module seg_lcd_link_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sck = 1'b0, sdi = 1'b0, cmd_sel = 1'b0, cs_n = 1'b1, panel_rst_n = 1'b1;
  logic [4:0] scan_addr = 5'd0;
  logic [3:0] scan_data;
  logic [1:0] disp_mode;

  int checks = 0, fails = 0;
  bit busy = 1'b1;
  string cur_req = "R12";

  // behavioural reference
  int       m_addr = 0;
  int       m_mode = 0;
  int       m_mem [32];
  bit       known [32];
  int       last_scan = 0;

  always #10 clk = ~clk;

  seg_lcd_link u_seg_lcd_link (
    .clk(clk), .rst(rst), .sck(sck), .sdi(sdi), .cmd_sel(cmd_sel), .cs_n(cs_n),
    .panel_rst_n(panel_rst_n), .scan_addr(scan_addr), .scan_data(scan_data),
    .disp_mode(disp_mode));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_apply(logic [7:0] w, bit is_cmd);
    if (!is_cmd) begin
      m_mem[m_addr] = int'(w[7:4]); known[m_addr] = 1'b1;
      m_addr = (m_addr + 1) % 32;
      m_mem[m_addr] = int'(w[3:0]); known[m_addr] = 1'b1;
      m_addr = (m_addr + 1) % 32;
    end else begin
      case (w[7:5])
        3'b000: m_addr = int'(w[4:0]);
        3'b001: m_mode = 1;
        3'b010: m_mode = 0;
        3'b011: m_mode = 2;
        3'b100: begin
          m_mem[m_addr] = int'(w[3:0]); known[m_addr] = 1'b1;
          m_addr = (m_addr + 1) % 32;
        end
        3'b110: begin m_mode = 0; m_addr = 0; end
        default: ;
      endcase
    end
  endtask

  task automatic clock_bits(logic [7:0] w, int n, bit cd_last, bit cd_early);
    for (int i = 0; i < n; i++) begin
      sdi = w[7-i];
      cmd_sel = (i == 7) ? cd_last : cd_early;
      repeat (6) @(negedge clk);
      sck = 1'b1;
      repeat (8) @(negedge clk);
      sck = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic send(logic [7:0] w, bit cd_last, bit cd_early, string req);
    busy = 1'b1;
    cur_req = req;
    clock_bits(w, 8, cd_last, cd_early);
    repeat (10) @(negedge clk);
    model_apply(w, cd_last);
    busy = 1'b0;
    repeat (70) @(negedge clk);
  endtask

  // compare the model every clock while the link is quiet (R11 read timing)
  initial begin
    forever begin
      @(negedge clk);
      if (!busy) begin
        check({cur_req, "/mode"}, int'(disp_mode), m_mode);
        if (known[last_scan])
          check({cur_req, "/R11 scan"}, int'(scan_data), m_mem[last_scan]);
      end
      last_scan = (last_scan + 7) % 32;
      scan_addr = 5'(last_scan);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin m_mem[i] = 0; known[i] = 1'b0; end
    repeat (5) @(negedge clk);
    check("R12 reset mode", int'(disp_mode), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R12 mode after reset", int'(disp_mode), 0);
    cs_n = 1'b0;
    repeat (10) @(negedge clk);
    busy = 1'b0;

    // R2 R4 R5 R9: fill the whole memory, ending by wrapping to 0
    send(8'h00, 1'b1, 1'b1, "R5");
    for (int i = 0; i < 16; i++) send(8'((i * 37 + 3) & 8'hFF), 1'b0, 1'b0, "R4");
    // R6: mode commands, memory untouched
    send(8'h20, 1'b1, 1'b1, "R6");
    send(8'h4F, 1'b1, 1'b1, "R6");
    send(8'h7A, 1'b1, 1'b1, "R6");
    // R7: bit 4 ignored, address +1
    send(8'h05, 1'b1, 1'b1, "R5");
    send(8'h9A, 1'b1, 1'b1, "R7");
    send(8'h83, 1'b1, 1'b1, "R7");
    // R9: pair write at the top address wraps
    send(8'h1F, 1'b1, 1'b1, "R9");
    send(8'hC7, 1'b0, 1'b0, "R9");
    send(8'h8E, 1'b1, 1'b1, "R9");
    // R10: reserved codes leave state alone, next write lands at 2
    send(8'hE5, 1'b1, 1'b1, "R10");
    send(8'hB3, 1'b1, 1'b1, "R10");
    send(8'h81, 1'b1, 1'b1, "R10");
    // R3: select level counts only on the last edge
    send(8'h5D, 1'b0, 1'b1, "R3");
    send(8'h20, 1'b1, 1'b0, "R3");
    // R8: software clear
    send(8'hC0, 1'b1, 1'b1, "R8");
    send(8'h85, 1'b1, 1'b1, "R8");
    send(8'h60, 1'b1, 1'b1, "R8");
    // R8: panel reset pin
    send(8'h10, 1'b1, 1'b1, "R8");
    busy = 1'b1;
    panel_rst_n = 1'b0;
    repeat (6) @(negedge clk);
    panel_rst_n = 1'b1;
    repeat (6) @(negedge clk);
    m_mode = 0; m_addr = 0;
    busy = 1'b0;
    repeat (40) @(negedge clk);
    send(8'h86, 1'b1, 1'b1, "R8");
    send(8'h60, 1'b1, 1'b1, "R8");
    // R1: clocks while deselected have no effect
    busy = 1'b1;
    cur_req = "R1";
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    clock_bits(8'h40, 8, 1'b1, 1'b1);
    repeat (10) @(negedge clk);
    busy = 1'b0;
    repeat (40) @(negedge clk);
    // R1: partial word discarded by a new select
    busy = 1'b1;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    clock_bits(8'hFF, 3, 1'b1, 1'b1);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    busy = 1'b0;
    send(8'h20, 1'b1, 1'b1, "R1");
    send(8'h03, 1'b1, 1'b1, "R1");
    send(8'h84, 1'b1, 1'b1, "R1");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule